// File: doc/BRIEF.md
# Programmable Asynchronous Memory Bus Controller

This block sits between a simple internal request port and an external 16-bit asynchronous memory device, such as flash or SRAM, that has one chip select. An internal requester issues 16-bit or 32-bit reads and writes. Each external bus cycle is run as a setup phase, a strobe phase and a hold phase. Reads have their own three cycle counts and writes have their own three. A 32-bit request is carried out as two 16-bit bus cycles to consecutive halfword addresses.

Writes are posted. The requester is released on the clock that accepts the write, and the bus cycle then runs in the background. Reads block. Read data comes back on a valid/ready response channel once the bus data has been latched, and no new request is taken while a response is still waiting. A configuration input selects the chip-select mode. In normal mode the select covers the whole access. In select-strobe mode it is asserted only during the strobe phase. After every request a fixed idle turnaround, with every strobe released, keeps successive accesses apart on the bus. The data bus is presented as separate pad-side output, output-enable and input pins.

Top module: `async_mem_ctrl`

## Requirements
- R1: Each phase lasts its programmed count plus one clock. Reads use cfgRdSetup, cfgRdStrobe and cfgRdHold, and writes use cfgWrSetup, cfgWrStrobe and cfgWrHold, independently of each other.
- R2: A hold count of 0 leaves exactly one clock between the release of the read/write enable and the end of the access. A hold count of 5 leaves six clocks.
- R3: With cfgSelStrobe=0, memCsN is low (active) from the first setup clock to the last hold clock. With cfgSelStrobe=1, memCsN is low only on the clocks where memReN or memWeN is low.
- R4: A request with reqWide=1 runs two bus accesses, first at halfword address reqAddr and then at reqAddr+1. The low half of reqWdata goes to the first address. A wide read returns {data at reqAddr+1, data at reqAddr} in a single response after both accesses. In normal chip-select mode the select stays low across both accesses, with no turnaround between them.
- R5: A write is accepted on the first clock on which it is offered to an idle controller, and it never produces a response. The device receives the data while memWeN is low.
- R6: A read produces exactly one response. While rspValid is high and rspReady is low, rspValid and rspData hold steady, reqReady stays low and no bus access starts.
- R7: Read data is taken from memDataIn on the last clock of the read strobe phase. A narrow read returns it zero-extended in rspData[15:0].
- R8: memDataOe is high only during write accesses, from setup to hold. It is never high while memReN is low, nor in idle.
- R9: After each request ends, TURN_CYC clocks pass with every strobe high. The next access then starts one clock after the request is accepted, so a queued request sees a gap of TURN_CYC+1 high-select clocks.
- R10: Timing counts and chip-select mode are sampled when a request is accepted. A change made during an access affects only later requests.
- R11: After reset, memCsN, memReN and memWeN are high, memDataOe and rspValid are low, and reqReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request can be taken |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWide | input | 1 | 1 = 32-bit request, 0 = 16-bit |
| reqAddr | input | ADDR_W | Halfword address |
| reqWdata | input | 2*BUS_W | Write data, low half first |
| rspValid | output | 1 | Read data available |
| rspReady | input | 1 | Requester takes the read data |
| rspData | output | 2*BUS_W | Read data |
| cfgRdSetup | input | SETUP_W | Read setup count |
| cfgRdStrobe | input | STROBE_W | Read strobe count |
| cfgRdHold | input | HOLD_W | Read hold count |
| cfgWrSetup | input | SETUP_W | Write setup count |
| cfgWrStrobe | input | STROBE_W | Write strobe count |
| cfgWrHold | input | HOLD_W | Write hold count |
| cfgSelStrobe | input | 1 | 1 = select-strobe chip-select mode |
| memCsN | output | 1 | Chip select, active low |
| memReN | output | 1 | Read enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memAddr | output | ADDR_W | External halfword address |
| memDataOut | output | BUS_W | Data driven to the bus |
| memDataOe | output | 1 | Output enable for memDataOut |
| memDataIn | input | BUS_W | Data read from the bus |

## Verification
The hardest state to reach from the ports is a read response held back while another request is already waiting. The stimulus gets there by dropping rspReady, issuing a read, and offering a write while the response sits unclaimed. It then watches the select stay quiet and the response stay frozen, and releases rspReady to let the waiting write run. Strobe-edge data capture is checked with a bus model that drives inverted data on every strobe clock except the last, so a capture on any earlier clock corrupts the scoreboard comparison. Mid-access configuration changes are applied on the clock after acceptance, before the strobe phase begins.

// File: rtl/amcPkg.sv
package amcPkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_TURN
  } phase_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic accept;     // request taken this cycle
    logic opWrite;    // current operation is a write
    logic opWide;     // current operation is 32-bit
    logic upperHalf;  // second halfword of a wide operation
    logic driveCs;    // chip select active
    logic driveRe;    // read enable active
    logic driveWe;    // write enable active
    logic driveOe;    // data bus output enable
    logic capture;    // latch bus data this cycle
    logic rspSet;     // raise the read response this cycle
  } ctlStrobes_t;

endpackage

// File: rtl/amcControl.sv
module amcControl
  import amcPkg::*;
#(
  parameter int SETUP_W  = 4,
  parameter int STROBE_W = 6,
  parameter int HOLD_W   = 3,
  parameter int TURN_CYC = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic                reqWide,
  input  logic                rspPending,
  output logic                reqReady,
  input  logic [SETUP_W-1:0]  cfgRdSetup,
  input  logic [STROBE_W-1:0] cfgRdStrobe,
  input  logic [HOLD_W-1:0]   cfgRdHold,
  input  logic [SETUP_W-1:0]  cfgWrSetup,
  input  logic [STROBE_W-1:0] cfgWrStrobe,
  input  logic [HOLD_W-1:0]   cfgWrHold,
  input  logic                cfgSelStrobe,
  output ctlStrobes_t         ctl
);

  localparam int CNT_W = (STROBE_W >= SETUP_W && STROBE_W >= HOLD_W) ? STROBE_W :
                         ((SETUP_W >= HOLD_W) ? SETUP_W : HOLD_W);
  localparam int TURN_W = (TURN_CYC > 1) ? $clog2(TURN_CYC) : 1;

  phase_e             phase;
  logic [CNT_W-1:0]   cnt;
  logic [TURN_W-1:0]  turnCnt;
  logic               opWrite;
  logic               opWide;
  logic               upperHalf;
  logic               selStrobe;
  logic [CNT_W-1:0]   tSetup;
  logic [CNT_W-1:0]   tStrobe;
  logic [CNT_W-1:0]   tHold;
  logic               accept;
  logic               busy;
  logic               phaseDone;

  assign reqReady  = (phase == PH_IDLE) && !rspPending;
  assign accept    = reqValid && reqReady;
  assign busy      = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign phaseDone = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      turnCnt   <= '0;
      opWrite   <= 1'b0;
      opWide    <= 1'b0;
      upperHalf <= 1'b0;
      selStrobe <= 1'b0;
      tSetup    <= '0;
      tStrobe   <= '0;
      tHold     <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (accept) begin
            phase     <= PH_SETUP;
            opWrite   <= reqWrite;
            opWide    <= reqWide;
            upperHalf <= 1'b0;
            selStrobe <= cfgSelStrobe;
            if (reqWrite) begin
              tSetup  <= CNT_W'(cfgWrSetup);
              tStrobe <= CNT_W'(cfgWrStrobe);
              tHold   <= CNT_W'(cfgWrHold);
              cnt     <= CNT_W'(cfgWrSetup);
            end else begin
              tSetup  <= CNT_W'(cfgRdSetup);
              tStrobe <= CNT_W'(cfgRdStrobe);
              tHold   <= CNT_W'(cfgRdHold);
              cnt     <= CNT_W'(cfgRdSetup);
            end
          end
        end
        PH_SETUP: begin
          if (phaseDone) begin
            phase <= PH_STROBE;
            cnt   <= tStrobe;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_STROBE: begin
          if (phaseDone) begin
            phase <= PH_HOLD;
            cnt   <= tHold;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HOLD: begin
          if (phaseDone) begin
            if (opWide && !upperHalf) begin
              upperHalf <= 1'b1;
              phase     <= PH_SETUP;
              cnt       <= tSetup;
            end else begin
              phase   <= PH_TURN;
              turnCnt <= TURN_W'(TURN_CYC - 1);
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_TURN: begin
          if (turnCnt == '0) phase <= PH_IDLE;
          else               turnCnt <= turnCnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.accept    = accept;
    ctl.opWrite   = opWrite;
    ctl.opWide    = opWide;
    ctl.upperHalf = upperHalf;
    ctl.driveCs   = selStrobe ? (phase == PH_STROBE) : busy;
    ctl.driveRe   = (phase == PH_STROBE) && !opWrite;
    ctl.driveWe   = (phase == PH_STROBE) && opWrite;
    ctl.driveOe   = busy && opWrite;
    ctl.capture   = (phase == PH_STROBE) && phaseDone && !opWrite;
    ctl.rspSet    = (phase == PH_HOLD) && phaseDone && !opWrite && (!opWide || upperHalf);
  end

  // checker: strobe run length measured independently of the down counter
  logic [CNT_W:0] strobeRun;
  always_ff @(posedge clk) begin
    if (!rstN)                   strobeRun <= '0;
    else if (phase == PH_STROBE) strobeRun <= strobeRun + 1'b1;
    else                         strobeRun <= '0;
  end

  a_r1_strobe_len: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STROBE && cnt == '0) |-> (strobeRun == {1'b0, tStrobe}));

  a_r9_turn_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_TURN) |-> (!ctl.driveCs && !ctl.driveRe && !ctl.driveWe && !ctl.driveOe));

  a_r10_timing_held: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE && $past(phase) != PH_IDLE) |->
      ($stable(tSetup) && $stable(tStrobe) && $stable(tHold) && $stable(selStrobe)));

endmodule

// File: rtl/amcDatapath.sv
module amcDatapath
  import amcPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BUS_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         ctl,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [2*BUS_W-1:0]  reqWdata,
  input  logic                rspReady,
  output logic                rspValid,
  output logic [2*BUS_W-1:0]  rspData,
  output logic                memCsN,
  output logic                memReN,
  output logic                memWeN,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [BUS_W-1:0]    memDataOut,
  output logic                memDataOe,
  input  logic [BUS_W-1:0]    memDataIn
);

  logic [ADDR_W-1:0]  addrReg;
  logic [2*BUS_W-1:0] wdataReg;
  logic [BUS_W-1:0]   rdLo;
  logic [BUS_W-1:0]   rdHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      rdLo     <= '0;
      rdHi     <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      if (ctl.accept) begin
        addrReg  <= reqAddr;
        wdataReg <= reqWdata;
      end
      if (ctl.capture) begin
        if (ctl.upperHalf) rdHi <= memDataIn;
        else               rdLo <= memDataIn;
      end
      if (ctl.rspSet) begin
        rspValid <= 1'b1;
        rspData  <= ctl.opWide ? {rdHi, rdLo} : {{BUS_W{1'b0}}, rdLo};
      end else if (rspValid && rspReady) begin
        rspValid <= 1'b0;
      end
    end
  end

  assign memCsN     = !ctl.driveCs;
  assign memReN     = !ctl.driveRe;
  assign memWeN     = !ctl.driveWe;
  assign memDataOe  = ctl.driveOe;
  assign memAddr    = addrReg + ADDR_W'(ctl.upperHalf);
  assign memDataOut = ctl.upperHalf ? wdataReg[2*BUS_W-1:BUS_W] : wdataReg[BUS_W-1:0];

  a_r6_rsp_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspData)));

  a_r8_oe_not_read: assert property (@(posedge clk) disable iff (!rstN)
    memDataOe |-> memReN);

  a_r3_strobe_in_cs: assert property (@(posedge clk) disable iff (!rstN)
    (!memReN || !memWeN) |-> !memCsN);

  a_r7_capture_in_strobe: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |-> !memReN);

endmodule

// File: rtl/async_mem_ctrl.sv
module async_mem_ctrl
  import amcPkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BUS_W    = 16,
  parameter int SETUP_W  = 4,
  parameter int STROBE_W = 6,
  parameter int HOLD_W   = 3,
  parameter int TURN_CYC = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic                reqWide,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [2*BUS_W-1:0]  reqWdata,
  output logic                rspValid,
  input  logic                rspReady,
  output logic [2*BUS_W-1:0]  rspData,
  input  logic [SETUP_W-1:0]  cfgRdSetup,
  input  logic [STROBE_W-1:0] cfgRdStrobe,
  input  logic [HOLD_W-1:0]   cfgRdHold,
  input  logic [SETUP_W-1:0]  cfgWrSetup,
  input  logic [STROBE_W-1:0] cfgWrStrobe,
  input  logic [HOLD_W-1:0]   cfgWrHold,
  input  logic                cfgSelStrobe,
  output logic                memCsN,
  output logic                memReN,
  output logic                memWeN,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [BUS_W-1:0]    memDataOut,
  output logic                memDataOe,
  input  logic [BUS_W-1:0]    memDataIn
);

  ctlStrobes_t ctl;

  amcControl #(
    .SETUP_W (SETUP_W),
    .STROBE_W(STROBE_W),
    .HOLD_W  (HOLD_W),
    .TURN_CYC(TURN_CYC)
  ) uCtl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqWrite    (reqWrite),
    .reqWide     (reqWide),
    .rspPending  (rspValid),
    .reqReady    (reqReady),
    .cfgRdSetup  (cfgRdSetup),
    .cfgRdStrobe (cfgRdStrobe),
    .cfgRdHold   (cfgRdHold),
    .cfgWrSetup  (cfgWrSetup),
    .cfgWrStrobe (cfgWrStrobe),
    .cfgWrHold   (cfgWrHold),
    .cfgSelStrobe(cfgSelStrobe),
    .ctl         (ctl)
  );

  amcDatapath #(
    .ADDR_W(ADDR_W),
    .BUS_W (BUS_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .rspReady  (rspReady),
    .rspValid  (rspValid),
    .rspData   (rspData),
    .memCsN    (memCsN),
    .memReN    (memReN),
    .memWeN    (memWeN),
    .memAddr   (memAddr),
    .memDataOut(memDataOut),
    .memDataOe (memDataOe),
    .memDataIn (memDataIn)
  );

  a_r6_no_accept_pending: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

endmodule

// File: tb/sim_async_mem_ctrl.sv
module sim_async_mem_ctrl;

  localparam int TURN = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqWide = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        reqReady, rspValid;
  logic        rspReady = 1'b1;
  logic [31:0] rspData;
  logic [3:0]  cfgRdSetup = 4'd2, cfgWrSetup = 4'd1;
  logic [5:0]  cfgRdStrobe = 6'd3, cfgWrStrobe = 6'd4;
  logic [2:0]  cfgRdHold = 3'd1, cfgWrHold = 3'd2;
  logic        cfgSelStrobe = 1'b0;
  logic        memCsN, memReN, memWeN, memDataOe;
  logic [15:0] memAddr, memDataOut;
  logic [15:0] memDataIn = 16'h0BAD;

  always #5 clk = ~clk;

  async_mem_ctrl #(.TURN_CYC(TURN)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqWide(reqWide), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspReady(rspReady), .rspData(rspData),
    .cfgRdSetup(cfgRdSetup), .cfgRdStrobe(cfgRdStrobe), .cfgRdHold(cfgRdHold),
    .cfgWrSetup(cfgWrSetup), .cfgWrStrobe(cfgWrStrobe), .cfgWrHold(cfgWrHold),
    .cfgSelStrobe(cfgSelStrobe), .memCsN(memCsN), .memReN(memReN), .memWeN(memWeN),
    .memAddr(memAddr), .memDataOut(memDataOut), .memDataOe(memDataOe), .memDataIn(memDataIn)
  );

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference memory (updated by the driver) and bus memory (updated by the bus model)
  logic [15:0] refMem [256];
  logic [15:0] busMem [256];
  logic [31:0] expQ [$];
  logic [15:0] addrLog [$];

  // bus model and timing monitor state
  int mdlStrobe = 3;
  bit selMode = 1'b0;
  int rc = 0;
  int oeBad = 0, oeSeen = 0;
  int setupC = 0, strobeC = 0, holdC = 0, gapC = 0;
  int lastSetup = 0, lastStrobe = 0, lastHold = 0, lastGap = 0;
  bit prevCs = 1'b1, prevStb = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (!memReN) rc++; else rc = 0;
      if (!memReN)
        memDataIn = (rc == mdlStrobe + 1) ? busMem[memAddr[7:0]] : ~busMem[memAddr[7:0]];
      else
        memDataIn = 16'h0BAD;
      if (!memWeN) begin
        if (!memDataOe) oeBad++;
        busMem[memAddr[7:0]] = memDataOut;
      end
      if (memDataOe) oeSeen++;
      if (memDataOe && !memReN) oeBad++;
      if (memDataOe && memCsN && !selMode) oeBad++;
      if ((!memReN || !memWeN) && !prevStb) addrLog.push_back(memAddr);
      prevStb = !memReN || !memWeN;
      if (!memCsN) begin
        if (prevCs) begin
          lastGap = gapC; setupC = 0; strobeC = 0; holdC = 0;
        end
        if (!memReN || !memWeN) strobeC++;
        else if (strobeC == 0)  setupC++;
        else                    holdC++;
      end else begin
        if (!prevCs) begin
          lastSetup = setupC; lastStrobe = strobeC; lastHold = holdC; gapC = 0;
        end
        gapC++;
      end
      prevCs = memCsN;
    end
  end

  // scoreboard monitor: pops expected read data as responses are taken
  always @(negedge clk) begin
    if (rstN && rspValid && rspReady) begin
      if (expQ.size() == 0) begin
        check("R5", "response with no read outstanding", 1, 0);
      end else begin
        logic [31:0] e;
        e = expQ.pop_front();
        check("R7", "read data (R4 ordering)", rspData, e);
      end
    end
  end

  // driver: enters and leaves at a falling edge
  task automatic issue(input bit wr, input bit wide, input logic [15:0] a,
                       input logic [31:0] d, output int waited);
    waited   = 0;
    reqWrite = wr; reqWide = wide; reqAddr = a; reqWdata = d; reqValid = 1'b1;
    while (!reqReady) begin @(negedge clk); waited++; end
    if (!wr) expQ.push_back(wide ? {refMem[a[7:0]+8'd1], refMem[a[7:0]]} : {16'h0, refMem[a[7:0]]});
    else begin
      refMem[a[7:0]] = d[15:0];
      if (wide) refMem[a[7:0]+8'd1] = d[31:16];
    end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (!reqReady || rspValid || !memCsN);
    repeat (2) @(negedge clk);
  endtask

  task automatic checkTiming(input string req, input int s, input int st, input int h);
    check(req, "setup clocks", lastSetup, s);
    check(req, "strobe clocks", lastStrobe, st);
    check(req, "hold clocks", lastHold, h);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    int w;
    for (int i = 0; i < 256; i++) begin
      refMem[i] = 16'(i * 37 + 16'h1200) ^ 16'h5A5A;
      busMem[i] = refMem[i];
    end
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "memCsN", memCsN, 1);
    check("R11", "memReN", memReN, 1);
    check("R11", "memWeN", memWeN, 1);
    check("R11", "memDataOe", memDataOe, 0);
    check("R11", "rspValid", rspValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11", "reqReady", reqReady, 1);

    // R1 narrow read timing (rd 2/3/1) and R7 capture
    issue(0, 0, 16'd5, 32'h0, w);
    waitIdle();
    checkTiming("R1", 3, 4, 2);

    // R1/R5 narrow write timing (wr 1/4/2), posted
    issue(1, 0, 16'd9, 32'h0000_A5C3, w);
    check("R5", "write accepted on first offer", w, 0);
    waitIdle();
    checkTiming("R1", 2, 5, 3);
    check("R5", "device holds written data", busMem[9], 16'hA5C3);

    // R2 hold of zero and of five
    cfgRdHold = 3'd0;
    issue(0, 0, 16'd6, 32'h0, w);
    waitIdle();
    check("R2", "hold 0 gives one clock", lastHold, 1);
    cfgRdHold = 3'd5;
    issue(0, 0, 16'd7, 32'h0, w);
    waitIdle();
    check("R2", "hold 5 gives six clocks", lastHold, 6);
    cfgRdHold = 3'd1;

    // R4 wide read
    addrLog.delete();
    issue(0, 1, 16'd20, 32'h0, w);
    waitIdle();
    check("R4", "two strobes", addrLog.size(), 2);
    if (addrLog.size() == 2) begin
      check("R4", "first address", addrLog[0], 20);
      check("R4", "second address", addrLog[1], 21);
    end
    check("R4", "select held across both halves", lastSetup + lastStrobe + lastHold, 18);

    // R4 wide write
    addrLog.delete();
    issue(1, 1, 16'd30, 32'hBEEF_1234, w);
    waitIdle();
    check("R4", "low half at N", busMem[30], 16'h1234);
    check("R4", "high half at N+1", busMem[31], 16'hBEEF);
    check("R4", "write strobes", addrLog.size(), 2);

    // R3 select-strobe mode
    cfgSelStrobe = 1'b1; selMode = 1'b1;
    issue(0, 0, 16'd11, 32'h0, w);
    waitIdle();
    checkTiming("R3", 0, 4, 0);
    issue(1, 0, 16'd12, 32'h0000_3C3C, w);
    waitIdle();
    checkTiming("R3", 0, 5, 0);
    check("R3", "write data in select-strobe mode", busMem[12], 16'h3C3C);
    cfgSelStrobe = 1'b0; selMode = 1'b0;

    // R6 response held while requester stalls, pending write waits
    begin
      logic [31:0] d0;
      int csBusy, rdy, drop;
      rspReady = 1'b0;
      issue(0, 1, 16'd50, 32'h0, w);
      while (!rspValid) @(negedge clk);
      d0 = rspData;
      reqWrite = 1'b1; reqWide = 1'b0; reqAddr = 16'd40; reqWdata = 32'h7777; reqValid = 1'b1;
      csBusy = 0; rdy = 0; drop = 0;
      repeat (12) begin
        @(negedge clk);
        if (!memCsN) csBusy++;
        if (reqReady) rdy++;
        if (!rspValid || rspData != d0) drop++;
      end
      check("R6", "no bus access while response waits", csBusy, 0);
      check("R6", "reqReady low while response waits", rdy, 0);
      check("R6", "response held stable", drop, 0);
      check("R6", "held data value", d0, {refMem[51], refMem[50]});
      @(posedge clk); #1 rspReady = 1'b1;
      @(negedge clk);
      issue(1, 0, 16'd40, 32'h7777, w);
      waitIdle();
      check("R6", "queued write done after release", busMem[40], 16'h7777);
      check("R6", "scoreboard drained", expQ.size(), 0);
    end

    // R9 turnaround between queued writes
    issue(1, 0, 16'd60, 32'h1111, w);
    issue(1, 0, 16'd61, 32'h2222, w);
    waitIdle();
    check("R9", "gap between accesses", lastGap, TURN + 1);
    issue(0, 0, 16'd61, 32'h0, w);
    issue(1, 0, 16'd62, 32'h3333, w);
    waitIdle();
    check("R9", "gap after read", lastGap, TURN + 1);

    // R10 configuration sampled at acceptance
    mdlStrobe = 3;
    issue(0, 0, 16'd70, 32'h0, w);
    cfgRdStrobe = 6'd7;
    waitIdle();
    check("R10", "strobe kept for running access", lastStrobe, 4);
    mdlStrobe = 7;
    issue(0, 0, 16'd71, 32'h0, w);
    waitIdle();
    check("R10", "new strobe on next access", lastStrobe, 8);

    // R8 output enable discipline
    check("R8", "output enable violations", oeBad, 0);
    check("R8", "output enable seen in writes", oeSeen > 0, 1);
    check("R7", "all reads answered", expQ.size(), 0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule